// File: doc/BRIEF.md
# PWM Dead-Band Delay Generator

This block sits after the stage that shapes two raw PWM waveforms, A and B, and turns them into an output pair that is safe to drive the two switches of a half bridge. It has two delay paths. The rising path delays only the low-to-high edges of its source. The falling path delays only the high-to-low edges of its source. Each path picks its own source from A or B, and each has its own delay count. Both delayed signals can be inverted on their own. Each output can take either its delayed signal or its raw input.

The configuration is static for a run and comes in on plain input fields. Source edges are synchronous to the rising clock edge. A delay is measured from the rising clock edge after which the source changed. One delay unit is one clock period. With `half_en` set, one unit is half a clock period, and an output edge can then fall on the falling clock edge.

Top module: `pwm_deadband`

## Requirements
- R1: `in_mode` bit 0 picks the rising path source (0 = `in_a`, 1 = `in_b`) and bit 1 picks the falling path source. So mode 0 feeds A to both paths, 1 feeds B to the rising path and A to the falling path, 2 feeds A to the rising path and B to the falling path, and 3 feeds B to both paths.
- R2: Reset is asynchronous and active low, and leaves no delay pending. With both inputs low, `out_mode` 3 and `polarity` 2, `out_a` is 0 and `out_b` is 1 during reset and in the first cycle after it.
- R3: The rising path output goes high only after its source has stayed high for `rise_dly` units without a break. It goes low at once when the source goes low.
- R4: The falling path output goes low only after its source has stayed low for `fall_dly` units without a break. It goes high at once when the source goes high.
- R5: A delay count of 0 makes that path follow its source with no delay.
- R6: A source pulse shorter than the path's delay count leaves that path at its inactive level for the whole pulse.
- R7: When `out_mode` bit 0 is 1, `out_a` takes the rising path signal; when it is 0, `out_a` equals `in_a`. When `out_mode` bit 1 is 1, `out_b` takes the falling path signal; when it is 0, `out_b` equals `in_b`.
- R8: `polarity` bit 0 inverts the rising path signal and bit 1 inverts the falling path signal, before output routing.
- R9: When `half_en` is 1, one delay unit is half a clock period, so an odd count puts the output edge on a falling clock edge.
- R10: With `in_mode` 0 or 3, `out_mode` 3 and `polarity` 2, the outputs are never high together. `out_a` rises `rise_dly` units after `out_b` falls, and `out_b` rises `fall_dly` units after `out_a` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_en | input | 1 | 1 = delay unit is half a clock period |
| in_mode | input | 2 | Source select for the two delay paths |
| out_mode | input | 2 | Delayed or raw signal for each output |
| polarity | input | 2 | Inversion of the rising (bit 0) and falling (bit 1) path signals |
| rise_dly | input | CNT_W | Rising edge delay in units |
| fall_dly | input | CNT_W | Falling edge delay in units |
| in_a | input | 1 | PWM input A |
| in_b | input | 1 | PWM input B |
| out_a | output | 1 | Output A |
| out_b | output | 1 | Output B |

## Verification
The bench drives long, even square waves, where both delays show in full, and short pulses, where a count longer than the pulse must hide the pulse entirely. Zero counts, odd half-period counts and A and B waves with different periods complete the stimulus. The different periods make each source-select setting produce a different output pair. A sweep over every source, routing and polarity setting, in both unit sizes, compares each output against an edge-time model sampled after both clock edges. In the complementary settings the same sweep also checks that the two outputs are never high together.

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_en,
  input  logic [1:0]       in_mode,
  input  logic [1:0]       out_mode,
  input  logic [1:0]       polarity,
  input  logic [CNT_W-1:0] rise_dly,
  input  logic [CNT_W-1:0] fall_dly,
  input  logic             in_a,
  input  logic             in_b,
  output logic             out_a,
  output logic             out_b
);

  logic [1:0] src;
  logic [1:0] act;
  logic [1:0] gated;
  logic       rdly;
  logic       fdly;

  assign src[0] = in_mode[0] ? in_b : in_a;
  assign src[1] = in_mode[1] ? in_b : in_a;
  // rising path times the high phase, falling path times the low phase
  assign act[0] = src[0];
  assign act[1] = ~src[1];

  for (genvar g = 0; g < 2; g++) begin : g_path
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] elap;
    logic             half_hit;
    logic             done;

    assign limit = (g == 0) ? rise_dly : fall_dly;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          elap <= '1;
      else if (!act[g])    elap <= '0;
      else if (elap < limit) elap <= elap + 1'b1;
    end

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) half_hit <= 1'b1;
      else        half_hit <= act[g] && ({elap, 1'b1} >= {1'b0, limit});
    end

    assign done = (limit == '0) ||
                  (half_en ? (({elap, 1'b0} >= {1'b0, limit}) || half_hit)
                           : (elap >= limit));
    assign gated[g] = act[g] & done;
  end

  assign rdly  = gated[0];
  assign fdly  = ~gated[1];
  assign out_a = out_mode[0] ? (rdly ^ polarity[0]) : in_a;
  assign out_b = out_mode[1] ? (fdly ^ polarity[1]) : in_b;

  assert_rise_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_en && rise_dly != '0 && $rose(rdly)) |-> $past(src[0]));

  assert_fall_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_en && fall_dly != '0 && $fell(fdly)) |-> !$past(src[1]));

  assert_zero_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode[0] && !polarity[0] && rise_dly == '0) |-> (out_a == src[0]));

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_mode == 2'd0 || in_mode == 2'd3) && out_mode == 2'd3 && polarity == 2'd2)
      |-> !(out_a && out_b));

endmodule

// File: tb/pwm_deadband_bench.sv
module pwm_deadband_bench;
  localparam int W = 10;

  typedef struct packed { logic a; logic b; } pair_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_en = 1'b0;
  logic [1:0] in_mode = '0, out_mode = 2'd3, polarity = 2'd2;
  logic [W-1:0] rise_dly = '0, fall_dly = '0;
  logic in_a = 1'b0, in_b = 1'b0;
  logic out_a, out_b;

  pwm_deadband #(.CNT_W(W)) u_pwm_deadband (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .in_mode(in_mode),
    .out_mode(out_mode), .polarity(polarity), .rise_dly(rise_dly),
    .fall_dly(fall_dly), .in_a(in_a), .in_b(in_b), .out_a(out_a), .out_b(out_b));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int t = 0;
  int t_on [2];
  logic prev_act [2];
  pair_t q [$];
  string req = "R2";

  function automatic logic [1:0] activity();
    logic sr, sf;
    sr = in_mode[0] ? in_b : in_a;
    sf = in_mode[1] ? in_b : in_a;
    return {~sf, sr};
  endfunction

  function automatic pair_t model(int tt);
    logic [1:0] ac;
    int dr, df;
    logic g0, g1, pr, pf;
    ac = activity();
    dr = half_en ? int'(rise_dly) : 2 * int'(rise_dly);
    df = half_en ? int'(fall_dly) : 2 * int'(fall_dly);
    g0 = ac[0] && (tt - t_on[0] >= dr);
    g1 = ac[1] && (tt - t_on[1] >= df);
    pr = g0 ^ polarity[0];
    pf = ~g1 ^ polarity[1];
    return '{a: (out_mode[0] ? pr : in_a), b: (out_mode[1] ? pf : in_b)};
  endfunction

  function automatic logic complementary();
    return (in_mode == 2'd0 || in_mode == 2'd3) && out_mode == 2'd3 && polarity == 2'd2;
  endfunction

  task automatic check(input pair_t got, input pair_t exp, input string r);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s t=%0d actual a=%b b=%b expected a=%b b=%b", r, t, got.a, got.b, exp.a, exp.b);
    end
  endtask

  task automatic pop_check();
    pair_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      check('{a: out_a, b: out_b}, e, req);
      if (complementary()) begin
        checks++;
        if (out_a && out_b) begin
          errors++;
          $display("FAIL R10 overlap actual a=1 b=1 expected not both high");
        end
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #5; pop_check();
      @(negedge clk); #5; pop_check();
    end
  end

  task automatic drive(input logic a, input logic b);
    logic [1:0] ac;
    @(posedge clk); #1;
    in_a = a; in_b = b;
    ac = activity();
    for (int p = 0; p < 2; p++) begin
      if (ac[p] && !prev_act[p]) t_on[p] = t;
      prev_act[p] = ac[p];
    end
    q.push_back(model(t));
    q.push_back(model(t + 1));
    t += 2;
  endtask

  task automatic start_test(input logic [1:0] im, input logic [1:0] om, input logic [1:0] pl,
                            input logic hf, input int rd, input int fd, input string r);
    logic [1:0] ac;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b0; in_a = 1'b0; in_b = 1'b0;
    in_mode = im; out_mode = om; polarity = pl; half_en = hf;
    rise_dly = W'(rd); fall_dly = W'(fd);
    req = r;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t = 0;
    ac = activity();
    for (int p = 0; p < 2; p++) begin
      t_on[p] = -100000;
      prev_act[p] = ac[p];
    end
  endtask

  task automatic wave(input int pa, input int pb, input int n);
    for (int i = 0; i < n; i++)
      drive((i % pa) < pa / 2, ((i + 2) % pb) < pb / 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R2: reset state with no pending delay
    #5;
    check('{a: out_a, b: out_b}, '{a: 1'b0, b: 1'b1}, "R2 in reset");
    start_test(2'd0, 2'd3, 2'd2, 1'b0, 5, 7, "R2");
    #4;
    check('{a: out_a, b: out_b}, '{a: 1'b0, b: 1'b1}, "R2 after reset");

    // R3 R4 R10: complementary pair with long even pulses
    start_test(2'd0, 2'd3, 2'd2, 1'b0, 4, 6, "R3 R4 R10");
    wave(24, 24, 96);

    // R5: zero counts
    start_test(2'd0, 2'd3, 2'd0, 1'b0, 0, 0, "R5");
    wave(6, 6, 30);

    // R6: pulses shorter than the delay
    start_test(2'd0, 2'd3, 2'd2, 1'b0, 8, 8, "R6");
    wave(6, 6, 36);

    // R1: each source selection with distinct A and B waves
    for (int im = 0; im < 4; im++) begin
      start_test(2'(im), 2'd3, 2'd0, 1'b0, 2, 3, "R1");
      wave(10, 14, 56);
    end

    // R7: routing of each output
    for (int om = 0; om < 4; om++) begin
      start_test(2'd2, 2'(om), 2'd0, 1'b0, 3, 2, "R7");
      wave(12, 8, 48);
    end

    // R8: polarity
    for (int pl = 0; pl < 4; pl++) begin
      start_test(2'd0, 2'd3, 2'(pl), 1'b0, 3, 4, "R8");
      wave(14, 14, 42);
    end

    // R9: half-period units, odd and minimal counts
    start_test(2'd0, 2'd3, 2'd2, 1'b1, 5, 3, "R9");
    wave(16, 16, 64);
    start_test(2'd0, 2'd3, 2'd2, 1'b1, 1, 1, "R9 unit one");
    wave(8, 8, 32);

    // R1 R7 R8 R10 sweep of all settings in both unit sizes
    for (int im = 0; im < 4; im++)
      for (int om = 0; om < 4; om++)
        for (int pl = 0; pl < 4; pl++)
          for (int hf = 0; hf < 2; hf++) begin
            start_test(2'(im), 2'(om), 2'(pl), 1'(hf), 3 + im, 5 + pl, "R1 R7 R8 R10 sweep");
            wave(10 + om, 14, 40);
          end

    repeat (3) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule